// File: doc/BRIEF.md
# Matrix Keyboard Scanner with Key FIFO

The block walks a key matrix of up to eight scan lines by eight return lines. It drives one scan line at a time and examines one return line per clock. A full pass over the matrix is a frame of ROWS×COLS cycles. A return line reads high when open and low when its key closes the selected scan line. Keys that pass debounce are turned into code bytes and queued in an 8-entry FIFO. A level interrupt tells the CPU that a code is waiting. The CPU can also poll the count output instead.

A mode write chooses how the scan lines are driven and which key policy applies. The scan lines can be a binary row number for an external decoder, or one-hot. The policy is either N-key rollover or 2-key lockout. The rollover path works per key, one examination at a time. The lockout path is a small state machine that runs once per frame with three states:
- LOCK_IDLE: no candidate key.
- LOCK_PEND: one key was seen alone in the last frame.
- LOCK_HELD: the accepted key is still down.

Its transitions are:
- IDLE→PEND on a frame with exactly one closed key.
- PEND→HELD when the same lone key repeats; the key is pushed on this transition.
- PEND→PEND when a different lone key appears; it becomes the new candidate.
- PEND→IDLE on a frame with no key or with several keys.
- HELD→IDLE on an empty frame.
- HELD→PEND when a different key is found alone.
- HELD stays on frames with the same key or with several keys.

The CPU sees the oldest code on the read data port and pops it with a read strobe. A clear strobe empties the FIFO and clears the overrun flag.

Top module: `keymatrix_scanner`

## Requirements
- R1: After reset the FIFO is empty. `fifo_count`, `irq` and `overrun` are 0 and `rd_data` is 0x00. The mode is encoded scan lines with 2-key lockout, and the scan starts at row 0.
- R2: Each row is held for COLS cycles, rows run 0 to ROWS-1 and then wrap. In encoded mode `scan_out[2:0]` carries the row number and the higher bits are 0. In decoded mode only `scan_out[row]` is 1.
- R3: A key counts as closed when its return line is low while its row is driven; an open line reads high. Its code byte is bit 7 = 0, bit 6 = shift, bits 5:3 = row, bits 2:0 = column.
- R4: `shift_in` is sampled at the moment a key is accepted and is stored in bit 6 of that key's code.
- R5: A key is accepted only when it reads closed in two successive frames. A closure seen in one frame only is ignored. A held key is queued once, until it is released.
- R6: The FIFO holds 8 codes in arrival order, and `rd_data` shows the oldest code. A `rd_pop` pulse removes that code. A pop while the FIFO is empty has no effect, and `rd_data` reads 0x00 when empty.
- R7: `irq` is high exactly while `fifo_count` is non-zero.
- R8: With N-key rollover, every debounced key is queued on its own. Keys that become valid in the same frame are queued in scan order (row first, then column).
- R9: With 2-key lockout, a key is queued only after it is the sole closed key in two successive frames. A key pressed while another is held is queued only after it stays alone for two frames. Two keys pressed together are not queued.
- R10: A key accepted while the FIFO holds 8 codes is dropped and sets `overrun`. `overrun` stays set until a clear.
- R11: A `clr` pulse empties the FIFO and clears `overrun` on the next cycle.
- R12: A `cfg_we` pulse loads `cfg_decoded` and `cfg_nkro`, restarts the scan at row 0 and discards key tracking. Codes already in the FIFO are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Mode write strobe |
| cfg_decoded | input | 1 | 1 = one-hot scan lines, 0 = binary row number |
| cfg_nkro | input | 1 | 1 = N-key rollover, 0 = 2-key lockout |
| clr | input | 1 | Clear strobe: empties FIFO and overrun |
| rd_pop | input | 1 | Data read strobe: removes the oldest code |
| shift_in | input | 1 | Shift key level |
| ret_n | input | COLS | Return lines, low = closed |
| scan_out | output | ROWS | Scan line drive |
| rd_data | output | 8 | Oldest queued code, 0x00 when empty |
| fifo_count | output | $clog2(DEPTH+1) | Number of queued codes |
| irq | output | 1 | Key available |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The bench holds a key for less than one frame. A design without debounce would queue it. It presses two keys together under rollover and checks the scan order. A design that queued by press time, or that dropped one of the keys, would show the wrong head code or count. Under lockout it first adds a second key to a held one, then releases the first key, then presses a pair together. A wrong lockout machine queues the intruding key early or never, or accepts the pair. It closes nine keys at once to fill the FIFO past capacity. A wrong design overwrites the oldest entry or forgets overrun. It also writes the mode while a code is queued, to catch a mode write that flushes the FIFO.

// File: rtl/kms_pkg.sv
`timescale 1ns/1ps
package kms_pkg;
    typedef enum logic [1:0] {
        LOCK_IDLE = 2'd0,
        LOCK_PEND = 2'd1,
        LOCK_HELD = 2'd2
    } lock_state_t;

    function automatic logic [7:0] make_code(input logic sh, input logic [2:0] r, input logic [2:0] c);
        return {1'b0, sh, r, c};
    endfunction
endpackage

// File: rtl/kms_scan_timer.sv
`timescale 1ns/1ps
module kms_scan_timer #(
    parameter int ROWS = 8,
    parameter int COLS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic            mode_dec,
    output logic [2:0]      row,
    output logic [2:0]      col,
    output logic            frame_end,
    output logic [ROWS-1:0] scan_out
);
    localparam logic [2:0] LAST_ROW = 3'(ROWS - 1);
    localparam logic [2:0] LAST_COL = 3'(COLS - 1);

    logic [2:0] row_q, col_q;

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            row_q <= '0;
            col_q <= '0;
        end else if (col_q == LAST_COL) begin
            col_q <= '0;
            row_q <= (row_q == LAST_ROW) ? 3'd0 : row_q + 3'd1;
        end else begin
            col_q <= col_q + 3'd1;
        end
    end

    assign row       = row_q;
    assign col       = col_q;
    assign frame_end = (row_q == LAST_ROW) && (col_q == LAST_COL);

    for (genvar gi = 0; gi < ROWS; gi++) begin : g_line
        if (gi < 3) begin : g_low
            assign scan_out[gi] = mode_dec ? (row_q == 3'(gi)) : row_q[gi];
        end else begin : g_high
            assign scan_out[gi] = mode_dec && (row_q == 3'(gi));
        end
    end
endmodule

// File: rtl/kms_key_filter.sv
`timescale 1ns/1ps
module kms_key_filter
    import kms_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       nkro,
    input  logic [2:0] row,
    input  logic [2:0] col,
    input  logic       frame_end,
    input  logic       closed,
    input  logic       shift,
    output logic       push,
    output logic [7:0] code
);
    logic [63:0] seen_q, taken_q;
    logic [5:0]  idx;
    logic        nk_hit;

    assign idx    = {row, col};
    assign nk_hit = closed && seen_q[idx] && !taken_q[idx];

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            seen_q  <= '0;
            taken_q <= '0;
        end else begin
            seen_q[idx]  <= closed;
            taken_q[idx] <= closed && (taken_q[idx] || nk_hit);
        end
    end

    logic [1:0]  cnt_q, cnt_n;
    logic [5:0]  first_q, first_n, cand_q, cand_n;
    lock_state_t state_q, state_n;
    logic        lone, none, lock_fire, lock_push;

    always_comb begin
        cnt_n   = cnt_q;
        first_n = first_q;
        if (closed) begin
            cnt_n = (cnt_q == 2'd0) ? 2'd1 : 2'd2;
            if (cnt_q == 2'd0) first_n = idx;
        end
    end

    assign lone = (cnt_n == 2'd1);
    assign none = (cnt_n == 2'd0);

    always_ff @(posedge clk) begin
        if (!rst_n || restart || frame_end) begin
            cnt_q   <= '0;
            first_q <= '0;
        end else begin
            cnt_q   <= cnt_n;
            first_q <= first_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            state_q <= LOCK_IDLE;
            cand_q  <= '0;
        end else if (frame_end) begin
            state_q <= state_n;
            cand_q  <= cand_n;
        end
    end

    always_comb begin
        state_n   = state_q;
        cand_n    = cand_q;
        lock_fire = 1'b0;
        unique case (state_q)
            LOCK_IDLE: begin
                if (lone) begin
                    state_n = LOCK_PEND;
                    cand_n  = first_n;
                end
            end
            LOCK_PEND: begin
                if (lone && first_n == cand_q) begin
                    state_n   = LOCK_HELD;
                    lock_fire = 1'b1;
                end else if (lone) begin
                    cand_n = first_n;
                end else begin
                    state_n = LOCK_IDLE;
                end
            end
            LOCK_HELD: begin
                if (none) begin
                    state_n = LOCK_IDLE;
                end else if (lone && first_n != cand_q) begin
                    state_n = LOCK_PEND;
                    cand_n  = first_n;
                end
            end
            default: state_n = LOCK_IDLE;
        endcase
    end

    always_comb begin
        lock_push = frame_end && lock_fire;
        push      = nkro ? nk_hit : lock_push;
        code      = nkro ? make_code(shift, row, col)
                         : make_code(shift, cand_q[5:3], cand_q[2:0]);
    end
endmodule

// File: rtl/kms_fifo.sv
`timescale 1ns/1ps
module kms_fifo #(
    parameter  int DEPTH = 8,
    localparam int PW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [7:0]    din,
    input  logic          pop,
    output logic [7:0]    head,
    output logic [CW-1:0] count,
    output logic          overrun
);
    logic [7:0]    mem_q [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          ovr_q, full, do_push, do_pop;

    assign full    = (cnt_q == CW'(DEPTH));
    assign do_pop  = pop && (cnt_q != '0);
    assign do_push = push && (!full || do_pop);

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem_q[wr_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
            ovr_q <= 1'b0;
        end else begin
            if (do_push) wr_q <= step(wr_q);
            if (do_pop)  rd_q <= step(rd_q);
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
            if (push && !do_push) ovr_q <= 1'b1;
        end
    end

    assign head    = (cnt_q != '0) ? mem_q[rd_q] : 8'h00;
    assign count   = cnt_q;
    assign overrun = ovr_q;
endmodule

// File: rtl/keymatrix_scanner.sv
`timescale 1ns/1ps
module keymatrix_scanner #(
    parameter  int ROWS  = 8,
    parameter  int COLS  = 8,
    parameter  int DEPTH = 8,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic            cfg_decoded,
    input  logic            cfg_nkro,
    input  logic            clr,
    input  logic            rd_pop,
    input  logic            shift_in,
    input  logic [COLS-1:0] ret_n,
    output logic [ROWS-1:0] scan_out,
    output logic [7:0]      rd_data,
    output logic [CW-1:0]   fifo_count,
    output logic            irq,
    output logic            overrun
);
    logic       mode_dec_q, mode_nkro_q;
    logic [2:0] row, col;
    logic       frame_end, closed, push;
    logic [7:0] push_code;
    logic [7:0] ret_wide;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_dec_q  <= 1'b0;
            mode_nkro_q <= 1'b0;
        end else if (cfg_we) begin
            mode_dec_q  <= cfg_decoded;
            mode_nkro_q <= cfg_nkro;
        end
    end

    assign ret_wide = 8'({8'hFF, ret_n});
    assign closed   = !ret_wide[col];

    kms_scan_timer #(.ROWS(ROWS), .COLS(COLS)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(cfg_we), .mode_dec(mode_dec_q),
        .row(row), .col(col), .frame_end(frame_end), .scan_out(scan_out)
    );

    kms_key_filter u_filter (
        .clk(clk), .rst_n(rst_n), .restart(cfg_we), .nkro(mode_nkro_q),
        .row(row), .col(col), .frame_end(frame_end), .closed(closed),
        .shift(shift_in), .push(push), .code(push_code)
    );

    kms_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(clr), .push(push), .din(push_code),
        .pop(rd_pop), .head(rd_data), .count(fifo_count), .overrun(overrun)
    );

    assign irq = (fifo_count != '0);
endmodule

// File: rtl/kms_checker.sv
`timescale 1ns/1ps
module kms_checker #(
    parameter int ROWS  = 8,
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            clr,
    input logic            rd_pop,
    input logic            push,
    input logic            mode_dec_q,
    input logic [ROWS-1:0] scan_out,
    input logic [CW-1:0]   fifo_count,
    input logic            irq,
    input logic            overrun
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) fifo_count <= CW'(DEPTH)); // R10
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) clr |=> (fifo_count == '0) && !overrun); // R11
    AST_DECODED_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) mode_dec_q |-> $countones(scan_out) == 1); // R2
    AST_ENCODED_UPPER: assert property (@(posedge clk) disable iff (!rst_n) !mode_dec_q |-> (scan_out >> 3) == '0); // R2
    AST_POP_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n) (rd_pop && fifo_count != '0 && !push && !clr) |=> fifo_count == $past(fifo_count) - CW'(1)); // R6
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (overrun && !clr) |=> overrun); // R10
    AST_IRQ_FROM_PUSH: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq) |-> $past(push)); // R7
endmodule

bind keymatrix_scanner kms_checker #(.ROWS(ROWS), .DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .rd_pop(rd_pop), .push(push),
    .mode_dec_q(mode_dec_q), .scan_out(scan_out), .fifo_count(fifo_count),
    .irq(irq), .overrun(overrun)
);

// File: tb/sim_keymatrix_scanner.sv
`timescale 1ns/1ps
module sim_keymatrix_scanner;
    localparam int FRAME = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0, cfg_decoded = 1'b0, cfg_nkro = 1'b0;
    logic       clr = 1'b0, rd_pop = 1'b0, shift_in = 1'b0;
    logic [7:0] ret_n;
    logic [7:0] scan_out;
    logic [7:0] rd_data;
    logic [3:0] fifo_count;
    logic       irq, overrun;

    logic [63:0] key_map = '0;
    logic        dec_mode = 1'b0;
    int          n_checks = 0;
    int          n_fails  = 0;

    always #4 clk = ~clk;

    keymatrix_scanner u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_decoded(cfg_decoded),
        .cfg_nkro(cfg_nkro), .clr(clr), .rd_pop(rd_pop), .shift_in(shift_in),
        .ret_n(ret_n), .scan_out(scan_out), .rd_data(rd_data),
        .fifo_count(fifo_count), .irq(irq), .overrun(overrun)
    );

    function automatic logic [2:0] cur_row();
        logic [2:0] r;
        r = scan_out[2:0];
        if (dec_mode) begin
            r = 3'd0;
            for (int i = 0; i < 8; i++) if (scan_out[i]) r = 3'(i);
        end
        return r;
    endfunction

    always_comb begin
        for (int c = 0; c < 8; c++) ret_n[c] = !key_map[{cur_row(), 3'(c)}];
    end

    function automatic logic [7:0] kcode(input logic sh, input int r, input int c);
        return {1'b0, sh, 3'(r), 3'(c)};
    endfunction

    function automatic int kidx(input int r, input int c);
        return r * 8 + c;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic frames(input int n);
        repeat (n * FRAME) @(negedge clk);
    endtask

    task automatic align();
        while (cur_row() != 3'd7) @(negedge clk);
        while (cur_row() != 3'd0) @(negedge clk);
    endtask

    task automatic pulse_pop();
        rd_pop = 1'b1; @(negedge clk); rd_pop = 1'b0;
    endtask

    task automatic pulse_clr();
        clr = 1'b1; @(negedge clk); clr = 1'b0;
    endtask

    task automatic set_mode(input logic dec, input logic nk);
        cfg_decoded = dec; cfg_nkro = nk; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; dec_mode = dec;
    endtask

    task automatic t_reset();
        check("R1 count", fifo_count, 0);
        check("R1 irq", irq, 0);
        check("R1 overrun", overrun, 0);
        check("R1 rd_data", rd_data, 8'h00);
        check("R1 scan row0 encoded", scan_out, 0);
    endtask

    task automatic t_scan();
        align();
        for (int r = 0; r < 8; r++) begin
            check("R2 encoded scan", scan_out, r);
            repeat (8) @(negedge clk);
        end
        repeat (13) @(negedge clk);
        set_mode(1'b1, 1'b1);
        for (int r = 0; r < 8; r++) begin
            check("R2 R12 decoded scan restart", scan_out, 1 << r);
            repeat (8) @(negedge clk);
        end
    endtask

    task automatic t_single();
        align();
        key_map[kidx(3, 5)] = 1'b1;
        frames(4);
        check("R3 count", fifo_count, 1);
        check("R7 irq set", irq, 1);
        check("R3 code", rd_data, kcode(0, 3, 5));
        frames(3);
        check("R5 held once", fifo_count, 1);
        key_map = '0;
        frames(2);
        pulse_pop();
        check("R6 pop empties", fifo_count, 0);
        check("R7 irq clear", irq, 0);
        check("R6 empty data", rd_data, 8'h00);
        pulse_pop();
        check("R6 pop on empty", fifo_count, 0);
    endtask

    task automatic t_shift();
        shift_in = 1'b1;
        align();
        key_map[kidx(6, 2)] = 1'b1;
        frames(4);
        check("R4 shift code", rd_data, kcode(1, 6, 2));
        key_map = '0;
        shift_in = 1'b0;
        frames(2);
        pulse_pop();
    endtask

    task automatic t_debounce();
        align();
        key_map[kidx(1, 1)] = 1'b1;
        repeat (40) @(negedge clk);
        key_map = '0;
        frames(3);
        check("R5 one-frame press ignored", fifo_count, 0);
    endtask

    task automatic t_rollover();
        align();
        key_map[kidx(5, 1)] = 1'b1;
        key_map[kidx(2, 6)] = 1'b1;
        frames(4);
        check("R8 both queued", fifo_count, 2);
        check("R8 scan order first", rd_data, kcode(0, 2, 6));
        pulse_pop();
        check("R8 scan order second", rd_data, kcode(0, 5, 1));
        pulse_pop();
        key_map = '0;
        frames(2);
    endtask

    task automatic t_overrun();
        align();
        for (int c = 0; c < 8; c++) key_map[kidx(0, c)] = 1'b1;
        key_map[kidx(1, 0)] = 1'b1;
        frames(4);
        check("R10 count full", fifo_count, 8);
        check("R10 overrun set", overrun, 1);
        check("R10 oldest kept", rd_data, kcode(0, 0, 0));
        key_map = '0;
        frames(3);
        check("R10 overrun sticky", overrun, 1);
        pulse_clr();
        check("R11 clear count", fifo_count, 0);
        check("R11 clear overrun", overrun, 0);
    endtask

    task automatic t_mode_keeps_fifo();
        align();
        key_map[kidx(3, 5)] = 1'b1;
        frames(4);
        key_map = '0;
        frames(2);
        set_mode(1'b1, 1'b0);
        check("R12 fifo kept on mode write", fifo_count, 1);
        check("R12 code kept", rd_data, kcode(0, 3, 5));
        pulse_clr();
    endtask

    task automatic t_lockout();
        align();
        key_map[kidx(4, 4)] = 1'b1;
        frames(4);
        check("R9 lone key queued", fifo_count, 1);
        check("R9 lone key code", rd_data, kcode(0, 4, 4));
        key_map[kidx(1, 7)] = 1'b1;
        frames(4);
        check("R9 second key locked out", fifo_count, 1);
        key_map[kidx(4, 4)] = 1'b0;
        frames(4);
        check("R9 second key after release", fifo_count, 2);
        pulse_pop();
        check("R9 second key code", rd_data, kcode(0, 1, 7));
        key_map = '0;
        frames(3);
        pulse_clr();
        align();
        key_map[kidx(2, 2)] = 1'b1;
        key_map[kidx(6, 5)] = 1'b1;
        frames(4);
        check("R9 pair ignored", fifo_count, 0);
        key_map = '0;
        frames(2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_scan();
        t_single();
        t_shift();
        t_debounce();
        t_rollover();
        t_overrun();
        t_mode_keeps_fifo();
        t_lockout();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule